// File: doc/BRIEF.md
# TLB Invalidate Controller with Protection

This block owns the valid state of a two-level translation cache and carries out invalidate requests against it. The second level has two arrays. The first is a set-associative array, selected by a select value of 0. The second is a small fully associative array, selected by 1, where every entry has a protect flag. A first-level shadow array holds copies of second-level entries. Each shadow slot records which second-level array and index it was filled from. Software never addresses the shadow directly, so the hardware keeps it a subset of the second level at all times.

An invalidate request carries an effective address, an array-select bit and, inside the address, an invalidate-all flag. A single-address invalidate compares the page number against every valid entry of the selected array and clears all matches in one clock. An invalidate-all clears the whole selected array. Protected entries of the fully associative array survive both kinds. Any shadow slot whose source entry is cleared or overwritten is dropped in the same clock. When the broadcast enable input is high, each accepted invalidate is also offered on the bus as an address-only request. That request is held until the bus accepts it, and the controller stays busy and refuses new requests until then.

Top module: `tlb_inval_ctrl`

## Requirements
- R1: A request with reqEa[2] set (bit 61 when a 64-bit address is numbered from the most significant bit as 0) and reqTlbSel=0 clears every valid bit of the set-associative array at the accepting clock edge.
- R2: The same invalidate-all with reqTlbSel=1 clears every entry of the fully associative array except those written with wrProtect=1.
- R3: A single-address invalidate (reqEa[2]=0) with reqTlbSel=0 clears exactly those set-associative entries whose stored page number equals reqEa[12 +: EPN_W]. Entries with another page number, in the same set or elsewhere, stay valid. The entry index in that array is set*T0_WAYS+way, with set = page number modulo T0_SETS.
- R4: A single-address invalidate with reqTlbSel=1 clears every unprotected matching entry of the fully associative array, and leaves a protected matching entry valid.
- R5: A shadow slot becomes invalid at the same clock edge at which the second-level entry it was filled from is invalidated. Slots whose source survives stay valid.
- R6: A shadow fill whose source entry is not valid has no effect. Rewriting a second-level entry through the write port drops every shadow slot filled from it.
- R7: With broadcastEn=0, an accepted invalidate never raises bcastValid.
- R8: With broadcastEn=1, bcastValid rises one clock after acceptance, with bcastEa equal to the request address and bcastTlbSel equal to the select bit. All three hold steady until a clock with bcastReady high, after which bcastValid falls.
- R9: While a broadcast is pending, busy is 1 and reqReady is 0. A request presented then is ignored and leaves all valid bits unchanged.
- R10: After reset all valid bits are 0, bcastValid and busy are 0, and reqReady is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Invalidate request present |
| reqReady | output | 1 | Request can be accepted this clock |
| reqEa | input | EA_W | Request effective address; bit 2 is the invalidate-all flag |
| reqTlbSel | input | 1 | 0 = set-associative array, 1 = fully associative array |
| broadcastEn | input | 1 | Configuration: broadcast accepted invalidates on the bus |
| bcastValid | output | 1 | Address-only broadcast request pending |
| bcastReady | input | 1 | Bus accepts the broadcast |
| bcastEa | output | EA_W | Address carried by the broadcast |
| bcastTlbSel | output | 1 | Array select carried by the broadcast |
| busy | output | 1 | Broadcast outstanding |
| wrEn | input | 1 | Write a second-level entry |
| wrTlbSel | input | 1 | Array to write |
| wrSlot | input | SLOT_W | Way (set-associative) or entry index (fully associative) |
| wrEpn | input | EPN_W | Page number to store |
| wrProtect | input | 1 | Protect flag for fully associative entries |
| fillEn | input | 1 | Fill a shadow slot |
| fillSlot | input | L1_W | Shadow slot to fill |
| fillTlbSel | input | 1 | Source array of the fill |
| fillSrc | input | SRC_W | Source entry index |
| tlb0Valid | output | T0_N | Valid bits of the set-associative array |
| tlb1Valid | output | T1_N | Valid bits of the fully associative array |
| l1Valid | output | L1_N | Valid bits of the shadow |

## Verification
The sequence places two pages in the same set. It checks that a single invalidate removes only the matching way. A design that cleared by set index alone would lose the neighbour. A protected entry shares its page number with an unprotected one, so a design that ignored the protect flag on single-address invalidates would clear both. A design that dropped protection entirely would empty the array on invalidate-all. Shadow slots point at entries that are invalidated, kept, protected and rewritten. Stale back-pointer handling would show up as a shadow bit that stays set, or one that clears by mistake. A request is also presented while a broadcast is stalled. A controller that accepted it would change valid bits or overwrite the held broadcast address.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;
  typedef struct packed {
    logic applyInv;
    logic invAll;
    logic tlbSel;
  } inv_strobe_t;
endpackage

// File: rtl/tlbinv_ctrl.sv
module tlbinv_ctrl
  import tlbinv_pkg::*;
#(
  parameter int EA_W        = 64,
  parameter int INV_ALL_BIT = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [EA_W-1:0] reqEa,
  input  logic            reqTlbSel,
  input  logic            broadcastEn,
  input  logic            bcastReady,
  output logic            reqReady,
  output logic            busy,
  output logic            bcastValid,
  output logic [EA_W-1:0] bcastEa,
  output logic            bcastTlbSel,
  output inv_strobe_t     stb
);
  logic accept;

  assign accept   = reqValid && !bcastValid;
  assign reqReady = !bcastValid;
  assign busy     = bcastValid;

  always_comb begin
    stb.applyInv = accept;
    stb.invAll   = reqEa[INV_ALL_BIT];
    stb.tlbSel   = reqTlbSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bcastValid  <= 1'b0;
      bcastEa     <= '0;
      bcastTlbSel <= 1'b0;
    end else if (accept && broadcastEn) begin
      bcastValid  <= 1'b1;
      bcastEa     <= reqEa;
      bcastTlbSel <= reqTlbSel;
    end else if (bcastValid && bcastReady) begin
      bcastValid  <= 1'b0;
    end
  end
endmodule

// File: rtl/tlbinv_dp.sv
module tlbinv_dp
  import tlbinv_pkg::*;
#(
  parameter int EPN_W   = 20,
  parameter int T0_SETS = 4,
  parameter int T0_WAYS = 2,
  parameter int T1_N    = 4,
  parameter int L1_N    = 4,
  localparam int SET_W  = $clog2(T0_SETS),
  localparam int WAY_W  = $clog2(T0_WAYS),
  localparam int T0_N   = T0_SETS * T0_WAYS,
  localparam int IDX0_W = $clog2(T0_N),
  localparam int IDX1_W = $clog2(T1_N),
  localparam int SRC_W  = (IDX0_W > IDX1_W) ? IDX0_W : IDX1_W,
  localparam int SLOT_W = (WAY_W > IDX1_W) ? WAY_W : IDX1_W,
  localparam int L1_W   = $clog2(L1_N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  inv_strobe_t      stb,
  input  logic [EPN_W-1:0] reqEpn,
  input  logic             wrEn,
  input  logic             wrTlbSel,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [EPN_W-1:0] wrEpn,
  input  logic             wrProtect,
  input  logic             fillEn,
  input  logic [L1_W-1:0]  fillSlot,
  input  logic             fillTlbSel,
  input  logic [SRC_W-1:0] fillSrc,
  output logic [T0_N-1:0]  tlb0Valid,
  output logic [T1_N-1:0]  tlb1Valid,
  output logic [L1_N-1:0]  l1Valid
);
  logic [EPN_W-1:0] t0Epn [T0_N];
  logic [EPN_W-1:0] t1Epn [T1_N];
  logic [T1_N-1:0]  t1Prot;
  logic [SRC_W-1:0] l1Src [L1_N];
  logic [L1_N-1:0]  l1Sel;

  logic [T0_N-1:0] t0Hit, t0Clr, t0Wr;
  logic [T1_N-1:0] t1Hit, t1Clr, t1Wr;
  logic [L1_N-1:0] l1Kill;
  logic [IDX0_W-1:0] t0WrIdx;
  logic [SET_W-1:0]  reqSet;
  logic              srcOk;

  assign reqSet  = reqEpn[SET_W-1:0];
  assign t0WrIdx = {wrEpn[SET_W-1:0], wrSlot[WAY_W-1:0]};

  // match and clear masks for both second-level arrays
  always_comb begin
    for (int i = 0; i < T0_N; i++) begin
      t0Hit[i] = tlb0Valid[i] && (SET_W'(i / T0_WAYS) == reqSet) && (t0Epn[i] == reqEpn);
      t0Clr[i] = stb.applyInv && !stb.tlbSel && (stb.invAll || t0Hit[i]);
      t0Wr[i]  = wrEn && !wrTlbSel && (t0WrIdx == IDX0_W'(i));
    end
    for (int i = 0; i < T1_N; i++) begin
      t1Hit[i] = tlb1Valid[i] && (t1Epn[i] == reqEpn);
      t1Clr[i] = stb.applyInv && stb.tlbSel && (stb.invAll || t1Hit[i]) && !t1Prot[i];
      t1Wr[i]  = wrEn && wrTlbSel && (wrSlot == SLOT_W'(i));
    end
  end

  // shadow back-pointer tracking
  always_comb begin
    srcOk = 1'b0;
    for (int k = 0; k < T0_N; k++)
      if (!fillTlbSel && fillSrc == SRC_W'(k)) srcOk = tlb0Valid[k];
    for (int k = 0; k < T1_N; k++)
      if (fillTlbSel && fillSrc == SRC_W'(k)) srcOk = tlb1Valid[k];
    for (int j = 0; j < L1_N; j++) begin
      l1Kill[j] = 1'b0;
      for (int k = 0; k < T0_N; k++)
        if (!l1Sel[j] && l1Src[j] == SRC_W'(k) && (t0Clr[k] || t0Wr[k])) l1Kill[j] = 1'b1;
      for (int k = 0; k < T1_N; k++)
        if (l1Sel[j] && l1Src[j] == SRC_W'(k) && (t1Clr[k] || t1Wr[k])) l1Kill[j] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tlb0Valid <= '0;
      tlb1Valid <= '0;
      t1Prot    <= '0;
      l1Valid   <= '0;
      l1Sel     <= '0;
      for (int i = 0; i < T0_N; i++) t0Epn[i] <= '0;
      for (int i = 0; i < T1_N; i++) t1Epn[i] <= '0;
      for (int j = 0; j < L1_N; j++) l1Src[j] <= '0;
    end else begin
      for (int i = 0; i < T0_N; i++) begin
        if (t0Wr[i]) t0Epn[i] <= wrEpn;
        tlb0Valid[i] <= (tlb0Valid[i] || t0Wr[i]) && !t0Clr[i];
      end
      for (int i = 0; i < T1_N; i++) begin
        if (t1Wr[i]) begin
          t1Epn[i]  <= wrEpn;
          t1Prot[i] <= wrProtect;
        end
        tlb1Valid[i] <= (tlb1Valid[i] || t1Wr[i]) && !t1Clr[i];
      end
      for (int j = 0; j < L1_N; j++) begin
        if (fillEn && srcOk && fillSlot == L1_W'(j)) begin
          l1Valid[j] <= 1'b1;
          l1Sel[j]   <= fillTlbSel;
          l1Src[j]   <= fillSrc;
        end else if (l1Kill[j]) begin
          l1Valid[j] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/tlb_inval_ctrl.sv
module tlb_inval_ctrl
  import tlbinv_pkg::*;
#(
  parameter int EA_W    = 64,
  parameter int EPN_W   = 20,
  parameter int T0_SETS = 4,
  parameter int T0_WAYS = 2,
  parameter int T1_N    = 4,
  parameter int L1_N    = 4,
  localparam int PAGE_LSB    = 12,
  localparam int INV_ALL_BIT = EA_W - 1 - 61,
  localparam int WAY_W  = $clog2(T0_WAYS),
  localparam int T0_N   = T0_SETS * T0_WAYS,
  localparam int IDX0_W = $clog2(T0_N),
  localparam int IDX1_W = $clog2(T1_N),
  localparam int SRC_W  = (IDX0_W > IDX1_W) ? IDX0_W : IDX1_W,
  localparam int SLOT_W = (WAY_W > IDX1_W) ? WAY_W : IDX1_W,
  localparam int L1_W   = $clog2(L1_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [EA_W-1:0]   reqEa,
  input  logic              reqTlbSel,
  input  logic              broadcastEn,
  output logic              bcastValid,
  input  logic              bcastReady,
  output logic [EA_W-1:0]   bcastEa,
  output logic              bcastTlbSel,
  output logic              busy,
  input  logic              wrEn,
  input  logic              wrTlbSel,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [EPN_W-1:0]  wrEpn,
  input  logic              wrProtect,
  input  logic              fillEn,
  input  logic [L1_W-1:0]   fillSlot,
  input  logic              fillTlbSel,
  input  logic [SRC_W-1:0]  fillSrc,
  output logic [T0_N-1:0]   tlb0Valid,
  output logic [T1_N-1:0]   tlb1Valid,
  output logic [L1_N-1:0]   l1Valid
);
  inv_strobe_t stb;

  tlbinv_ctrl #(.EA_W(EA_W), .INV_ALL_BIT(INV_ALL_BIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqEa(reqEa),
    .reqTlbSel(reqTlbSel), .broadcastEn(broadcastEn), .bcastReady(bcastReady),
    .reqReady(reqReady), .busy(busy), .bcastValid(bcastValid),
    .bcastEa(bcastEa), .bcastTlbSel(bcastTlbSel), .stb(stb)
  );

  tlbinv_dp #(.EPN_W(EPN_W), .T0_SETS(T0_SETS), .T0_WAYS(T0_WAYS),
              .T1_N(T1_N), .L1_N(L1_N)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqEpn(reqEa[PAGE_LSB +: EPN_W]),
    .wrEn(wrEn), .wrTlbSel(wrTlbSel), .wrSlot(wrSlot), .wrEpn(wrEpn),
    .wrProtect(wrProtect), .fillEn(fillEn), .fillSlot(fillSlot),
    .fillTlbSel(fillTlbSel), .fillSrc(fillSrc), .tlb0Valid(tlb0Valid),
    .tlb1Valid(tlb1Valid), .l1Valid(l1Valid)
  );
endmodule

// File: rtl/tlb_inval_ctrl_chk.sv
module tlb_inval_ctrl_chk #(
  parameter int EA_W = 64,
  parameter int T0_N = 8,
  parameter int T1_N = 4,
  parameter int INV_ALL_BIT = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic [EA_W-1:0] reqEa,
  input logic            reqTlbSel,
  input logic            broadcastEn,
  input logic            bcastValid,
  input logic            bcastReady,
  input logic [EA_W-1:0] bcastEa,
  input logic            bcastTlbSel,
  input logic            busy,
  input logic            wrEn,
  input logic [T0_N-1:0] tlb0Valid,
  input logic [T1_N-1:0] tlb1Valid
);
  AST_INVALL_TLB0_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && !reqTlbSel && reqEa[INV_ALL_BIT] && !wrEn |=> tlb0Valid == '0); // R1
  AST_NO_BCAST_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && !broadcastEn |=> !bcastValid); // R7
  AST_BCAST_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && broadcastEn |=> bcastValid && bcastEa == $past(reqEa) && bcastTlbSel == $past(reqTlbSel)); // R8
  AST_BCAST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    bcastValid && !bcastReady |=> bcastValid && $stable(bcastEa) && $stable(bcastTlbSel)); // R8
  AST_BUSY_FREEZES_L2: assert property (@(posedge clk) disable iff (!rstN)
    busy && !wrEn |=> $stable(tlb0Valid) && $stable(tlb1Valid)); // R9
endmodule

bind tlb_inval_ctrl tlb_inval_ctrl_chk #(.EA_W(EA_W), .T0_N(T0_N), .T1_N(T1_N),
  .INV_ALL_BIT(INV_ALL_BIT)) u_chk (.*);

// File: tb/tlb_inval_ctrl_test.sv
`timescale 1ns/1ps
module tlb_inval_ctrl_test;
  localparam int EA_W = 64, EPN_W = 20, SETS = 4, WAYS = 2, T0N = 8, T1N = 4, L1N = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, reqTlbSel = 0, broadcastEn = 0, bcastReady = 0;
  logic [EA_W-1:0] reqEa = '0;
  logic wrEn = 0, wrTlbSel = 0, wrProtect = 0;
  logic [1:0] wrSlot = '0;
  logic [EPN_W-1:0] wrEpn = '0;
  logic fillEn = 0, fillTlbSel = 0;
  logic [1:0] fillSlot = '0;
  logic [2:0] fillSrc = '0;
  logic reqReady, bcastValid, bcastTlbSel, busy;
  logic [EA_W-1:0] bcastEa;
  logic [T0N-1:0] tlb0Valid;
  logic [T1N-1:0] tlb1Valid;
  logic [L1N-1:0] l1Valid;

  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  tlb_inval_ctrl uut (.*);

  // behavioural reference
  int m0v[T0N], m0e[T0N], m1v[T1N], m1e[T1N], m1p[T1N];
  int lv[L1N], ls[L1N], lsrc[L1N];
  int mbv, mbsel;
  logic [EA_W-1:0] mbea;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      foreach (m0v[i]) begin m0v[i] = 0; m0e[i] = 0; end
      foreach (m1v[i]) begin m1v[i] = 0; m1e[i] = 0; m1p[i] = 0; end
      foreach (lv[i]) begin lv[i] = 0; ls[i] = 0; lsrc[i] = 0; end
      mbv = 0; mbsel = 0; mbea = '0;
    end else begin
      int gone0[T0N], gone1[T1N], clr0[T0N], clr1[T1N];
      int acc, epn, all, okSrc;
      acc = reqValid && !mbv;
      epn = int'(reqEa[12 +: EPN_W]);
      all = reqEa[2];
      foreach (clr0[i]) begin
        clr0[i] = acc && !reqTlbSel && (all || (m0v[i] && m0e[i] == epn));
        gone0[i] = clr0[i] || (wrEn && !wrTlbSel && i == (int'(wrEpn) % SETS) * WAYS + int'(wrSlot));
      end
      foreach (clr1[i]) begin
        clr1[i] = acc && reqTlbSel && !m1p[i] && (all || (m1v[i] && m1e[i] == epn));
        gone1[i] = clr1[i] || (wrEn && wrTlbSel && i == int'(wrSlot));
      end
      okSrc = fillTlbSel ? (fillSrc < T1N && m1v[fillSrc]) : m0v[fillSrc];
      foreach (lv[j]) begin
        if (lv[j] && (ls[j] ? gone1[lsrc[j]] : gone0[lsrc[j]])) lv[j] = 0;
        if (fillEn && okSrc && j == int'(fillSlot)) begin
          lv[j] = 1; ls[j] = fillTlbSel; lsrc[j] = fillSrc;
        end
      end
      if (wrEn && !wrTlbSel) begin
        m0v[(int'(wrEpn) % SETS) * WAYS + int'(wrSlot)] = 1;
        m0e[(int'(wrEpn) % SETS) * WAYS + int'(wrSlot)] = int'(wrEpn);
      end
      if (wrEn && wrTlbSel) begin
        m1v[wrSlot] = 1; m1e[wrSlot] = int'(wrEpn); m1p[wrSlot] = wrProtect;
      end
      foreach (clr0[i]) if (clr0[i]) m0v[i] = 0;
      foreach (clr1[i]) if (clr1[i]) m1v[i] = 0;
      if (acc && broadcastEn) begin
        mbv = 1; mbea = reqEa; mbsel = reqTlbSel;
      end else if (mbv && bcastReady) mbv = 0;
    end
  end

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rstN) begin
    logic [T0N-1:0] e0; logic [T1N-1:0] e1; logic [L1N-1:0] el;
    foreach (m0v[i]) e0[i] = m0v[i] != 0;
    foreach (m1v[i]) e1[i] = m1v[i] != 0;
    foreach (lv[i]) el[i] = lv[i] != 0;
    chk(64'(tlb0Valid), 64'(e0), "R3 model tlb0Valid");
    chk(64'(tlb1Valid), 64'(e1), "R4 model tlb1Valid");
    chk(64'(l1Valid), 64'(el), "R5 model l1Valid");
    chk(64'(bcastValid), 64'(mbv), "R8 model bcastValid");
    if (mbv) chk(bcastEa, mbea, "R8 model bcastEa");
    chk(64'(busy), 64'(mbv), "R9 model busy");
  end

  function automatic logic [EA_W-1:0] ea(input int epn, input bit all);
    return (64'(epn) << 12) | (all ? 64'd4 : 64'd0);
  endfunction

  task automatic wr(input bit sel, input int slot, input int epn, input bit prot);
    wrEn = 1; wrTlbSel = sel; wrSlot = 2'(slot); wrEpn = EPN_W'(epn); wrProtect = prot;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic fill(input int slot, input bit sel, input int src);
    fillEn = 1; fillSlot = 2'(slot); fillTlbSel = sel; fillSrc = 3'(src);
    @(negedge clk); fillEn = 0;
  endtask

  task automatic inv(input bit sel, input int epn, input bit all);
    reqValid = 1; reqTlbSel = sel; reqEa = ea(epn, all);
    @(negedge clk); reqValid = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(64'({tlb0Valid, tlb1Valid, l1Valid}), 64'd0, "R10 valids after reset");
    chk(64'({bcastValid, busy, reqReady}), 64'd1, "R10 handshake after reset");

    wr(0, 0, 'h101, 0); wr(0, 1, 'h205, 0); wr(0, 0, 'h102, 0); wr(0, 1, 'h333, 0);
    wr(1, 0, 'h500, 0); wr(1, 1, 'h501, 1); wr(1, 2, 'h500, 1); wr(1, 3, 'h777, 0);
    chk(64'(tlb0Valid), 64'h9C, "R3 tlb0 loaded");
    chk(64'(tlb1Valid), 64'hF, "R4 tlb1 loaded");

    fill(3, 0, 5);
    chk(64'(l1Valid), 64'h0, "R6 fill from invalid source ignored");
    fill(0, 0, 2); fill(1, 1, 0); fill(2, 1, 2); fill(3, 0, 7);
    chk(64'(l1Valid), 64'hF, "R5 shadow filled");

    inv(0, 'h101, 0);
    chk(64'(tlb0Valid), 64'h98, "R3 single invalidate same set");
    chk(64'(l1Valid), 64'hE, "R5 shadow follows tlb0 invalidate");

    inv(1, 'h500, 0);
    chk(64'(tlb1Valid), 64'hE, "R4 protected match kept");
    chk(64'(l1Valid), 64'hC, "R5 shadow follows tlb1 invalidate");
    chk(64'(bcastValid), 64'd0, "R7 no broadcast when disabled");

    wr(0, 1, 'h073, 0);
    chk(64'(tlb0Valid), 64'h98, "R6 rewrite keeps tlb0 valid");
    chk(64'(l1Valid), 64'h4, "R6 rewrite drops shadow");

    broadcastEn = 1;
    inv(1, 'h0, 1);
    chk(64'(tlb1Valid), 64'h6, "R2 invalidate-all spares protected");
    chk(64'(l1Valid), 64'h4, "R5 shadow of protected kept");
    chk(64'(bcastValid), 64'd1, "R8 broadcast raised");
    chk(bcastEa, ea(0, 1), "R8 broadcast address");
    chk(64'(bcastTlbSel), 64'd1, "R8 broadcast select");
    chk(64'(reqReady), 64'd0, "R9 not ready while pending");
    @(negedge clk); @(negedge clk);
    chk(64'(bcastValid), 64'd1, "R8 broadcast held");
    inv(0, 'h0, 1);
    chk(64'(tlb0Valid), 64'h98, "R9 request ignored while busy");
    chk(bcastEa, ea(0, 1), "R9 held address unchanged");
    bcastReady = 1;
    @(negedge clk); bcastReady = 0;
    chk(64'(bcastValid), 64'd0, "R8 broadcast retired");
    chk(64'(reqReady), 64'd1, "R9 ready again");

    broadcastEn = 0;
    inv(0, 'h0, 1);
    chk(64'(tlb0Valid), 64'h0, "R1 invalidate-all tlb0");
    chk(64'(tlb1Valid), 64'h6, "R1 tlb1 untouched");
    @(negedge clk);
    chk(64'(bcastValid), 64'd0, "R7 still no broadcast");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule